// File: doc/BRIEF.md
# Supervisor Call Entry Sequencer

This block carries a small processor core into and out of a supervisor call. When a call strobe arrives, it looks at the mode field of the status word it is given. If the core is in one of the two least privileged modes, the block only records a return address in a link register and redirects the program counter to the supervisor vector. From any other mode it saves the return address and the status word on the system stack, each through its own pre-decremented write. It then forces the mode field to supervisor and redirects the program counter to the same vector.

A return strobe undoes whichever path the last call took. After a link-register entry the program counter reloads from the link register. After a stacking entry the block reads the status word and then the return address back from the stack, incrementing the stack pointer after each read. Stack traffic goes through a single-request memory port with a valid/ready handshake, and the sequencer waits on every request until it is accepted. A one-cycle done pulse marks the end of each entry or return. The vector is formed as base OR offset, the return address is the call's program counter plus the instruction size, and the stack pointer, mode-field position and word size are parameters.

Top module: `svc_seq`

## Requirements
- R1: A call accepted while the mode field (status bits 24:22) is 000 or 001 sets the link register to PC+2, sets the program counter to vector base OR 0x100 and copies the status input unchanged. It makes no memory request, and done rises one cycle after the strobe.
- R2: A call accepted in any other mode issues exactly two write requests. The first writes PC+2 to SP-4 and the second writes the status word to SP-8. The stack pointer then ends at SP-8.
- R3: After the second push of a stacking entry, the status output equals the saved status word with bits 24:22 replaced by 001, and the program counter equals vector base OR 0x100. The link register is left unchanged.
- R4: A return following a link-register entry loads the program counter from the link register. It leaves the status word and stack pointer unchanged and makes no memory request.
- R5: A return following a stacking entry issues two reads, first at SP and then at SP+4. The status output takes the first read's data and the program counter takes the second's, and the stack pointer ends 8 higher.
- R6: While a request is valid and ready is low, the request's address, direction and write data hold steady, and the sequence does not advance.
- R7: done is high for exactly one cycle per entry or return: one cycle after the strobe on the link-register paths, or one cycle after the last accepted memory request on the stacking paths.
- R8: After reset the program counter and link register read 0, the status word reads 0x0040_0000 (mode 001), the stack pointer reads 0x0000_2000, and neither a request nor done is asserted.
- R9: Strobes that arrive while a stacking sequence is in progress are ignored. A call and a return in the same idle cycle perform the call only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Supervisor call strobe |
| ret_i | input | 1 | Supervisor return strobe |
| pc_i | input | 32 | Program counter of the calling instruction |
| sr_i | input | 32 | Current status word, mode field at bits 24:22 |
| vbase_i | input | 32 | Exception vector base, low 9 bits zero |
| mem_valid_o | output | 1 | Stack memory request valid |
| mem_write_o | output | 1 | Request is a write (1) or read (0) |
| mem_addr_o | output | 32 | Request byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the current request |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| pc_o | output | 32 | Next program counter |
| lr_o | output | 32 | Link register |
| sr_o | output | 32 | Updated status word |
| sp_o | output | 32 | System stack pointer |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that the vector base has its low nine bits clear, since the OR would otherwise corrupt the base. They also assume that the memory holds read data valid in the cycle that ready is high. The stimulus uses only aligned bases. Its memory model returns data for the address on the port in the same cycle that it raises ready, and it varies ready among always-high, a one-in-three pattern and held low, so that every stall path is reached.

// File: rtl/svc_pkg.sv
package svc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PUSH_RA = 3'd1,
      ST_PUSH_SR = 3'd2,
      ST_POP_SR  = 3'd3,
      ST_POP_RA  = 3'd4
   } svc_state_e;

endpackage

// File: rtl/svc_mode_class.sv
module svc_mode_class #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned MODE_LSB   = 22,
   parameter int unsigned MODE_W     = 3,
   parameter int unsigned LOW_MODES  = 2,
   parameter int unsigned SUPER_MODE = 1
) (
   input  logic [XLEN-1:0] sr_i,
   output logic            is_low_o,
   output logic [XLEN-1:0] sr_forced_o
);

   logic [MODE_W-1:0] mode;

   assign mode = sr_i[MODE_LSB +: MODE_W];

   generate
      if (LOW_MODES == 2) begin : g_pair
         assign is_low_o = (mode == MODE_W'(0)) || (mode == MODE_W'(1));
      end else begin : g_cmp
         assign is_low_o = (mode < MODE_W'(LOW_MODES));
      end
   endgenerate

   always_comb begin
      sr_forced_o = sr_i;
      sr_forced_o[MODE_LSB +: MODE_W] = MODE_W'(SUPER_MODE);
   end

endmodule

// File: rtl/svc_vector.sv
module svc_vector #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned VEC_OFFSET = 32'h100,
   parameter bit          JOIN_OR    = 1'b1
) (
   input  logic [XLEN-1:0] base_i,
   output logic [XLEN-1:0] vec_o
);

   localparam logic [XLEN-1:0] OFFS = XLEN'(VEC_OFFSET);

   generate
      if (JOIN_OR) begin : g_or
         assign vec_o = base_i | OFFS;
      end else begin : g_add
         assign vec_o = base_i + OFFS;
      end
   endgenerate

endmodule

// File: rtl/svc_sp_unit.sv
module svc_sp_unit #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned SP_INIT = 32'h0000_2000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dec_i,
   input  logic            inc_i,
   output logic [XLEN-1:0] sp_o
);

   localparam logic [XLEN-1:0] WORD  = XLEN'(XLEN / 8);
   localparam logic [XLEN-1:0] START = XLEN'(SP_INIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_o <= START;
      end else if (dec_i) begin
         sp_o <= sp_o - WORD;
      end else if (inc_i) begin
         sp_o <= sp_o + WORD;
      end
   end

   AST_SP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_i && inc_i)); // R2

endmodule

// File: rtl/svc_ctrl.sv
module svc_ctrl
   import svc_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned MODE_LSB    = 22,
   parameter int unsigned MODE_W      = 3,
   parameter int unsigned SUPER_MODE  = 1,
   parameter int unsigned INSTR_BYTES = 2,
   parameter int unsigned RESET_PC    = 0,
   parameter int unsigned RESET_SR    = 32'h0040_0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            call_i,
   input  logic            ret_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] sr_i,
   input  logic            is_low_i,
   input  logic [XLEN-1:0] sr_forced_i,
   input  logic [XLEN-1:0] vec_i,
   input  logic [XLEN-1:0] sp_i,
   output logic            sp_dec_o,
   output logic            sp_inc_o,
   output logic            mem_valid_o,
   output logic            mem_write_o,
   output logic [XLEN-1:0] mem_addr_o,
   output logic [XLEN-1:0] mem_wdata_o,
   input  logic            mem_ready_i,
   input  logic [XLEN-1:0] mem_rdata_i,
   output logic [XLEN-1:0] pc_o,
   output logic [XLEN-1:0] lr_o,
   output logic [XLEN-1:0] sr_o,
   output logic            done_o,
   output logic            busy_o
);

   localparam logic [XLEN-1:0] WORD = XLEN'(XLEN / 8);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

   svc_state_e      state;
   logic [XLEN-1:0] ra_q;
   logic [XLEN-1:0] srsave_q;
   logic [XLEN-1:0] forced_q;
   logic [XLEN-1:0] vec_q;
   logic [XLEN-1:0] srbuf_q;
   logic            stacked_q;
   logic            hs;
   logic            is_push;

   assign busy_o      = (state != ST_IDLE);
   assign mem_valid_o = busy_o;
   assign is_push     = (state == ST_PUSH_RA) || (state == ST_PUSH_SR);
   assign mem_write_o = is_push;
   assign hs          = mem_valid_o && mem_ready_i;
   assign sp_dec_o    = hs && is_push;
   assign sp_inc_o    = hs && !is_push;

   always_comb begin
      mem_addr_o  = is_push ? (sp_i - WORD) : sp_i;
      mem_wdata_o = '0;
      if (state == ST_PUSH_RA) mem_wdata_o = ra_q;
      if (state == ST_PUSH_SR) mem_wdata_o = srsave_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ra_q      <= '0;
         srsave_q  <= '0;
         forced_q  <= '0;
         vec_q     <= '0;
         srbuf_q   <= '0;
         stacked_q <= 1'b0;
         pc_o      <= XLEN'(RESET_PC);
         lr_o      <= '0;
         sr_o      <= XLEN'(RESET_SR);
         done_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (call_i) begin
                  if (is_low_i) begin
                     lr_o      <= pc_i + STEP;
                     pc_o      <= vec_i;
                     sr_o      <= sr_i;
                     stacked_q <= 1'b0;
                     done_o    <= 1'b1;
                  end else begin
                     ra_q     <= pc_i + STEP;
                     srsave_q <= sr_i;
                     forced_q <= sr_forced_i;
                     vec_q    <= vec_i;
                     state    <= ST_PUSH_RA;
                  end
               end else if (ret_i) begin
                  if (stacked_q) begin
                     state <= ST_POP_SR;
                  end else begin
                     pc_o   <= lr_o;
                     done_o <= 1'b1;
                  end
               end
            end
            ST_PUSH_RA: begin
               if (hs) state <= ST_PUSH_SR;
            end
            ST_PUSH_SR: begin
               if (hs) begin
                  pc_o      <= vec_q;
                  sr_o      <= forced_q;
                  stacked_q <= 1'b1;
                  done_o    <= 1'b1;
                  state     <= ST_IDLE;
               end
            end
            ST_POP_SR: begin
               if (hs) begin
                  srbuf_q <= mem_rdata_i;
                  state   <= ST_POP_RA;
               end
            end
            ST_POP_RA: begin
               if (hs) begin
                  pc_o      <= mem_rdata_i;
                  sr_o      <= srbuf_q;
                  stacked_q <= 1'b0;
                  done_o    <= 1'b1;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_LOW_ENTRY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && call_i && is_low_i) |=> (done_o && !mem_valid_o && lr_o == $past(pc_i) + STEP)); // R1

   AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PUSH_RA && hs) |=> (mem_write_o && mem_addr_o == $past(mem_addr_o) - WORD)); // R2

   AST_STACK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PUSH_SR && hs) |=> (done_o && sr_o[MODE_LSB +: MODE_W] == MODE_W'(SUPER_MODE))); // R3

   AST_LR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !call_i && ret_i && !stacked_q) |=> (done_o && pc_o == lr_o && !mem_valid_o)); // R4

   AST_POP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_POP_SR && hs) |=> (!mem_write_o && mem_addr_o == $past(mem_addr_o) + WORD)); // R5

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_write_o) && $stable(mem_wdata_o))); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !hs) |=> ($stable(pc_o) && $stable(sr_o) && $stable(lr_o) && !done_o)); // R9

endmodule

// File: rtl/svc_seq.sv
module svc_seq #(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned MODE_LSB    = 22,
   parameter int unsigned MODE_W      = 3,
   parameter int unsigned LOW_MODES   = 2,
   parameter int unsigned SUPER_MODE  = 1,
   parameter int unsigned VEC_OFFSET  = 32'h100,
   parameter bit          JOIN_OR     = 1'b1,
   parameter int unsigned INSTR_BYTES = 2,
   parameter int unsigned SP_INIT     = 32'h0000_2000,
   parameter int unsigned RESET_PC    = 0,
   parameter int unsigned RESET_SR    = 32'h0040_0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            call_i,
   input  logic            ret_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] sr_i,
   input  logic [XLEN-1:0] vbase_i,
   output logic            mem_valid_o,
   output logic            mem_write_o,
   output logic [XLEN-1:0] mem_addr_o,
   output logic [XLEN-1:0] mem_wdata_o,
   input  logic            mem_ready_i,
   input  logic [XLEN-1:0] mem_rdata_i,
   output logic [XLEN-1:0] pc_o,
   output logic [XLEN-1:0] lr_o,
   output logic [XLEN-1:0] sr_o,
   output logic [XLEN-1:0] sp_o,
   output logic            done_o
);

   localparam int unsigned VEC_SPAN = 2 * VEC_OFFSET;

   generate
      if (MODE_LSB + MODE_W > XLEN) begin : g_bad_mode
         $error("mode field lies outside the status word");
      end
      if (XLEN % 8 != 0) begin : g_bad_xlen
         $error("word width must be whole bytes");
      end
      if (LOW_MODES > (1 << MODE_W)) begin : g_bad_low
         $error("low mode count exceeds mode field range");
      end
      if (SUPER_MODE >= (1 << MODE_W)) begin : g_bad_super
         $error("supervisor mode does not fit the mode field");
      end
   endgenerate

   logic            is_low;
   logic [XLEN-1:0] sr_forced;
   logic [XLEN-1:0] vec;
   logic            sp_dec;
   logic            sp_inc;
   logic            busy;

   svc_mode_class #(
      .XLEN       (XLEN),
      .MODE_LSB   (MODE_LSB),
      .MODE_W     (MODE_W),
      .LOW_MODES  (LOW_MODES),
      .SUPER_MODE (SUPER_MODE)
   ) u_mode (
      .sr_i        (sr_i),
      .is_low_o    (is_low),
      .sr_forced_o (sr_forced)
   );

   svc_vector #(
      .XLEN       (XLEN),
      .VEC_OFFSET (VEC_OFFSET),
      .JOIN_OR    (JOIN_OR)
   ) u_vec (
      .base_i (vbase_i),
      .vec_o  (vec)
   );

   svc_sp_unit #(
      .XLEN    (XLEN),
      .SP_INIT (SP_INIT)
   ) u_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .dec_i (sp_dec),
      .inc_i (sp_inc),
      .sp_o  (sp_o)
   );

   svc_ctrl #(
      .XLEN        (XLEN),
      .MODE_LSB    (MODE_LSB),
      .MODE_W      (MODE_W),
      .SUPER_MODE  (SUPER_MODE),
      .INSTR_BYTES (INSTR_BYTES),
      .RESET_PC    (RESET_PC),
      .RESET_SR    (RESET_SR)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .call_i      (call_i),
      .ret_i       (ret_i),
      .pc_i        (pc_i),
      .sr_i        (sr_i),
      .is_low_i    (is_low),
      .sr_forced_i (sr_forced),
      .vec_i       (vec),
      .sp_i        (sp_o),
      .sp_dec_o    (sp_dec),
      .sp_inc_o    (sp_inc),
      .mem_valid_o (mem_valid_o),
      .mem_write_o (mem_write_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .mem_ready_i (mem_ready_i),
      .mem_rdata_i (mem_rdata_i),
      .pc_o        (pc_o),
      .lr_o        (lr_o),
      .sr_o        (sr_o),
      .done_o      (done_o),
      .busy_o      (busy)
   );

   generate
      if (JOIN_OR) begin : g_align_chk
         AST_VBASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            (call_i && !busy) |-> ((vbase_i & XLEN'(VEC_SPAN - 1)) == '0)); // R3
      end
   endgenerate

endmodule

// File: tb/svc_seq_tb.sv
module svc_seq_tb;

   localparam logic [31:0] MODE_MASK = 32'h01C0_0000;
   localparam logic [31:0] SUPER_SR  = 32'h0040_0000;
   localparam logic [31:0] SP0       = 32'h0000_2000;

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [31:0] data;
   } txn_t;

   typedef struct packed {
      logic [31:0] pc;
      logic [31:0] lr;
      logic [31:0] sr;
      logic [31:0] sp;
   } res_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_i = 1'b0;
   logic        ret_i = 1'b0;
   logic [31:0] pc_i = '0;
   logic [31:0] sr_i = '0;
   logic [31:0] vbase_i = '0;
   logic        mem_valid_o;
   logic        mem_write_o;
   logic [31:0] mem_addr_o;
   logic [31:0] mem_wdata_o;
   logic        mem_ready_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;
   logic [31:0] pc_o;
   logic [31:0] lr_o;
   logic [31:0] sr_o;
   logic [31:0] sp_o;
   logic        done_o;

   always #4 clk = ~clk;

   svc_seq u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .call_i      (call_i),
      .ret_i       (ret_i),
      .pc_i        (pc_i),
      .sr_i        (sr_i),
      .vbase_i     (vbase_i),
      .mem_valid_o (mem_valid_o),
      .mem_write_o (mem_write_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .mem_ready_i (mem_ready_i),
      .mem_rdata_i (mem_rdata_i),
      .pc_o        (pc_o),
      .lr_o        (lr_o),
      .sr_o        (sr_o),
      .sp_o        (sp_o),
      .done_o      (done_o)
   );

   txn_t  exp_txn[$];
   string txn_tag[$];
   res_t  exp_res[$];
   string res_tag[$];
   logic [31:0] mem_model [logic [31:0]];

   int n_cmp = 0;
   int n_bad = 0;
   int done_cnt = 0;
   int ready_mode = 0;
   int cyc = 0;

   logic [31:0] m_pc = 32'h0;
   logic [31:0] m_lr = 32'h0;
   logic [31:0] m_sr = SUPER_SR;
   logic [31:0] m_sp = SP0;
   logic        m_stacked = 1'b0;
   logic [31:0] m_save_ra = 32'h0;
   logic [31:0] m_save_sr = 32'h0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // memory ready generator, driven just after each rising edge
   always @(posedge clk) begin
      #1;
      cyc++;
      case (ready_mode)
         0: mem_ready_i = 1'b1;
         1: mem_ready_i = ((cyc % 3) == 2);
         default: mem_ready_i = 1'b0;
      endcase
   end

   // monitor: scoreboard for memory requests and completions
   logic        prev_wait = 1'b0;
   logic        prev_done = 1'b0;
   logic [31:0] prev_addr = '0;
   logic [31:0] prev_wdata = '0;
   logic        prev_wr = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_wait) begin
            check("R6 stalled request valid", {31'b0, mem_valid_o}, 32'h1);
            check("R6 stalled address", mem_addr_o, prev_addr);
            check("R6 stalled write data", mem_wdata_o, prev_wdata);
            check("R6 stalled direction", {31'b0, mem_write_o}, {31'b0, prev_wr});
         end
         if (mem_valid_o && mem_ready_i) begin
            if (exp_txn.size() == 0) begin
               check("R9 unexpected memory request", mem_addr_o, 32'hFFFF_FFFF);
            end else begin
               txn_t  t;
               string tg;
               t  = exp_txn.pop_front();
               tg = txn_tag.pop_front();
               check({tg, " direction"}, {31'b0, mem_write_o}, {31'b0, t.wr});
               check({tg, " address"}, mem_addr_o, t.addr);
               if (t.wr) check({tg, " write data"}, mem_wdata_o, t.data);
            end
            if (mem_write_o) mem_model[mem_addr_o] = mem_wdata_o;
         end
         prev_wait  = mem_valid_o && !mem_ready_i;
         prev_addr  = mem_addr_o;
         prev_wdata = mem_wdata_o;
         prev_wr    = mem_write_o;
         if (mem_valid_o && mem_model.exists(mem_addr_o))
            mem_rdata_i = mem_model[mem_addr_o];
         else
            mem_rdata_i = '0;
         if (prev_done) check("R7 done lasts one cycle", {31'b0, done_o}, 32'h0);
         if (done_o) begin
            if (exp_res.size() == 0) begin
               check("R9 unexpected done", 32'h1, 32'h0);
            end else begin
               res_t  r;
               string tg;
               r  = exp_res.pop_front();
               tg = res_tag.pop_front();
               check({tg, " pc"}, pc_o, r.pc);
               check({tg, " lr"}, lr_o, r.lr);
               check({tg, " sr"}, sr_o, r.sr);
               check({tg, " sp"}, sp_o, r.sp);
               check({tg, " all requests done"}, exp_txn.size(), 0);
            end
            done_cnt++;
         end
         prev_done = done_o;
      end
   end

   task automatic push_res(input string tag);
      exp_res.push_back('{pc: m_pc, lr: m_lr, sr: m_sr, sp: m_sp});
      res_tag.push_back(tag);
   endtask

   task automatic expect_call(input logic [31:0] pc, input logic [31:0] sr,
                              input logic [31:0] vb, input string tag);
      logic [31:0] ra;
      ra = pc + 32'd2;
      if (sr[24:22] == 3'b000 || sr[24:22] == 3'b001) begin
         m_lr = ra;
         m_pc = vb | 32'h100;
         m_sr = sr;
         m_stacked = 1'b0;
      end else begin
         exp_txn.push_back('{wr: 1'b1, addr: m_sp - 32'd4, data: ra});
         txn_tag.push_back({tag, " R2 first push"});
         exp_txn.push_back('{wr: 1'b1, addr: m_sp - 32'd8, data: sr});
         txn_tag.push_back({tag, " R2 second push"});
         m_sp = m_sp - 32'd8;
         m_pc = vb | 32'h100;
         m_sr = (sr & ~MODE_MASK) | SUPER_SR;
         m_save_ra = ra;
         m_save_sr = sr;
         m_stacked = 1'b1;
      end
      push_res(tag);
   endtask

   task automatic expect_ret(input string tag);
      if (m_stacked) begin
         exp_txn.push_back('{wr: 1'b0, addr: m_sp, data: 32'h0});
         txn_tag.push_back({tag, " R5 first pop"});
         exp_txn.push_back('{wr: 1'b0, addr: m_sp + 32'd4, data: 32'h0});
         txn_tag.push_back({tag, " R5 second pop"});
         m_sp = m_sp + 32'd8;
         m_pc = m_save_ra;
         m_sr = m_save_sr;
         m_stacked = 1'b0;
      end else begin
         m_pc = m_lr;
      end
      push_res(tag);
   endtask

   task automatic wait_done(input int start);
      while (done_cnt == start) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic do_call(input logic [31:0] pc, input logic [31:0] sr,
                          input logic [31:0] vb, input string tag);
      int start;
      start = done_cnt;
      expect_call(pc, sr, vb, tag);
      @(negedge clk);
      call_i = 1'b1; pc_i = pc; sr_i = sr; vbase_i = vb;
      @(negedge clk);
      call_i = 1'b0;
      wait_done(start);
   endtask

   task automatic do_ret(input string tag);
      int start;
      start = done_cnt;
      expect_ret(tag);
      @(negedge clk);
      ret_i = 1'b1;
      @(negedge clk);
      ret_i = 1'b0;
      wait_done(start);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      check("R8 reset pc", pc_o, 32'h0);
      check("R8 reset lr", lr_o, 32'h0);
      check("R8 reset sr", sr_o, SUPER_SR);
      check("R8 reset sp", sp_o, SP0);
      check("R8 reset request", {31'b0, mem_valid_o}, 32'h0);
      check("R8 reset done", {31'b0, done_o}, 32'h0);

      // R1 / R4: link-register path from the two low modes
      ready_mode = 0;
      do_call(32'h0000_1000, 32'h0000_00A5, 32'h8000_0000, "R1 mode0 call");
      do_ret("R4 mode0 return");
      do_call(32'h0000_3456, 32'h005F_0003, 32'h1234_5000, "R1 mode1 call");
      do_ret("R4 mode1 return");

      // R2 / R3 / R5: stacking path
      do_call(32'h0000_4000, 32'h00C0_0012, 32'h8000_0200, "R3 mode3 call");
      do_ret("R5 mode3 return");

      // R6: stacking path under a stalling memory
      ready_mode = 1;
      do_call(32'h0000_7FFE, 32'hFFFF_FFFF, 32'h0001_0000, "R6 mode7 call");
      do_ret("R6 mode7 return");
      do_call(32'h0000_0100, 32'h0000_0001, 32'h0002_0000, "R6 mode0 call stalled");
      ready_mode = 0;

      // R9: strobes while busy are ignored
      begin
         int start;
         start = done_cnt;
         ready_mode = 2;
         expect_call(32'h0000_5000, 32'h0100_0044, 32'h4000_0000, "R9 busy call");
         @(negedge clk);
         call_i = 1'b1; pc_i = 32'h0000_5000; sr_i = 32'h0100_0044; vbase_i = 32'h4000_0000;
         @(negedge clk);
         call_i = 1'b0;
         repeat (3) @(negedge clk);
         call_i = 1'b1; ret_i = 1'b1; pc_i = 32'h0000_9990; sr_i = 32'h0;
         @(negedge clk);
         call_i = 1'b0; ret_i = 1'b0;
         repeat (2) @(negedge clk);
         ready_mode = 0;
         wait_done(start);
         repeat (4) @(negedge clk);
         check("R9 no extra request after busy strobes", {31'b0, mem_valid_o}, 32'h0);
      end

      // R9: call and return together from idle perform the call
      begin
         int start;
         start = done_cnt;
         expect_call(32'h0000_6000, 32'h0000_0007, 32'hA000_0000, "R9 call beats return");
         @(negedge clk);
         call_i = 1'b1; ret_i = 1'b1; pc_i = 32'h0000_6000; sr_i = 32'h0000_0007; vbase_i = 32'hA000_0000;
         @(negedge clk);
         call_i = 1'b0; ret_i = 1'b0;
         wait_done(start);
      end
      do_ret("R4 return after combined strobe");

      repeat (6) @(negedge clk);
      check("R7 expected completions drained", exp_res.size(), 0);
      check("R2 expected requests drained", exp_txn.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule